// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Status

This block takes in an asynchronous serial line and turns each character into a byte in a receive buffer. It also keeps a small status word with four flags: receive-full, overrun, noise and framing. The line is first brought into the clock domain through a flop chain. It is then sampled once per pulse of an external oversampling strobe, sixteen pulses to one bit time. Each bit is decided by a majority of three samples taken around the middle of the bit. If those three samples do not all agree, that disagreement is recorded as noise for the character.

A host reads the block through a plain read port. One select value returns the status word and the other returns the receive buffer. The shift register is separate from the receive buffer, so one character can be assembled while the previous one waits to be read. A flag is cleared by a status read that saw the flag set, followed by a read of the buffer. The block ranks overrun above framing. While a framing error is pending, no further character is loaded into the buffer.

Top module: `async_rx_status`

## Requirements
- R1: After reset, the status word reads 0x00 and the receive buffer reads 0x00.
- R2: A frame is one low start bit, eight data bits least significant first, and one high stop bit, each sixteen strobe pulses long. A complete frame sets status bit 0 (full) and loads the byte into the buffer. Select 0 reads status and select 1 reads the buffer.
- R3: Full clears only when a status read that saw full set is followed by a buffer read. A buffer read without such a status read leaves full set.
- R4: When a character completes while full is set, status bit 1 (overrun) is set. The new byte is dropped and the buffer keeps its old value.
- R5: Samples 7, 8 and 9 of each bit, start and stop included, are majority-voted. Any disagreement among them sets status bit 2 (noise) together with full for that character, and the voted value is the one stored.
- R6: A stop bit that votes low sets status bit 3 (framing) in the same cycle as full. The byte is still loaded.
- R7: While framing is set, a further character is not loaded into the buffer and sets overrun instead.
- R8: A character that has a bad stop bit and arrives while full is set reports overrun only. Framing stays clear.
- R9: Overrun, noise and framing each clear through the status-then-buffer read sequence. A status read taken while a flag was clear does not arm that flag's clear.
- R10: A low pulse on an idle line that has returned high by sample 7 is rejected as a false start and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Oversampling strobe, sixteen pulses per bit time |
| rxd_i | input | 1 | Asynchronous serial line, high when idle |
| rd_en_i | input | 1 | Read strobe; flag clearing acts on the clock edge |
| rd_sel_i | input | 1 | 0 selects the status word, 1 selects the receive buffer |
| rd_data_o | output | 8 | Read data for the selected register |

## Verification
On every cycle, the assertions check these relations:
- framing never stands without full;
- noise only rises together with full;
- the buffer holds still whenever an arriving character is refused, through overrun or a pending framing error;
- a character with a bad stop bit that lands on a full buffer never raises framing;
- full only falls after a buffer read;
- the bit counter stays in range, and the completion strobe lasts one cycle.

Some behaviour can only be shown by the bench scenarios. These are:
- whether the stored byte and flags match what was sent;
- that a glitch in the start, a data bit or the stop bit is voted out but still reported as noise;
- that a short low pulse is ignored;
- that a buffer read with no armed status read leaves the flags alone.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   // Status word layout, bit 0 upward: full, overrun, noise, framing.
   typedef struct packed {
      logic frame;
      logic noise;
      logic ovr;
      logic full;
   } rx_flags_t;

   localparam int unsigned FLAGS_W = $bits(rx_flags_t);

   typedef enum logic [0:0] {
      RX_IDLE   = 1'b0,
      RX_ACTIVE = 1'b1
   } rx_state_e;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/async_rx_sampler.sv
module async_rx_sampler
   import async_rx_pkg::*;
#(
   parameter int unsigned OVS    = 16,
   parameter int unsigned DATA_W = 8,
   parameter bit          VOTE3  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxs_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              noise_o,
   output logic              frame_err_o
);

   localparam int unsigned CNT_W    = $clog2(OVS);
   localparam int unsigned MID      = OVS / 2;
   localparam int unsigned DECIDE   = VOTE3 ? MID + 1 : MID;
   localparam int unsigned BIT_LAST = DATA_W + 1;
   localparam int unsigned IDX_W    = $clog2(DATA_W + 2);

   rx_state_e          state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic [DATA_W-1:0]  shreg_q;
   logic               noise_acc_q;
   logic               vote;
   logic               disagree;
   logic               decide_now;

   assign decide_now = tick_i && (state_q == RX_ACTIVE) && (cnt_q == CNT_W'(DECIDE));

   generate
      if (VOTE3) begin : g_vote3
         logic s_early_q, s_mid_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_early_q <= 1'b1;
               s_mid_q   <= 1'b1;
            end else if (tick_i && state_q == RX_ACTIVE) begin
               if (cnt_q == CNT_W'(MID - 1)) s_early_q <= rxs_i;
               if (cnt_q == CNT_W'(MID))     s_mid_q   <= rxs_i;
            end
         end
         assign vote     = (s_early_q & s_mid_q) | (s_early_q & rxs_i) | (s_mid_q & rxs_i);
         assign disagree = !((s_early_q == s_mid_q) && (s_mid_q == rxs_i));
      end else begin : g_vote1
         assign vote     = rxs_i;
         assign disagree = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RX_IDLE;
         cnt_q       <= '0;
         idx_q       <= '0;
         shreg_q     <= '0;
         noise_acc_q <= 1'b0;
         done_o      <= 1'b0;
         data_o      <= '0;
         noise_o     <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            unique case (state_q)
               RX_IDLE: begin
                  if (!rxs_i) begin
                     state_q     <= RX_ACTIVE;
                     cnt_q       <= CNT_W'(1);
                     idx_q       <= '0;
                     noise_acc_q <= 1'b0;
                  end
               end
               RX_ACTIVE: begin
                  cnt_q <= cnt_q + CNT_W'(1);
                  if (cnt_q == CNT_W'(OVS - 1)) idx_q <= idx_q + IDX_W'(1);
                  if (decide_now) begin
                     noise_acc_q <= noise_acc_q | disagree;
                     if (idx_q == '0) begin
                        if (vote) state_q <= RX_IDLE;
                     end else if (idx_q == IDX_W'(BIT_LAST)) begin
                        state_q     <= RX_IDLE;
                        done_o      <= 1'b1;
                        data_o      <= shreg_q;
                        noise_o     <= noise_acc_q | disagree;
                        frame_err_o <= ~vote;
                     end else begin
                        shreg_q <= {vote, shreg_q[DATA_W-1:1]};
                     end
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_ACTIVE) |-> (idx_q <= IDX_W'(BIT_LAST)));

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (state_q == RX_IDLE));

endmodule

// File: rtl/async_rx_regs.sv
module async_rx_regs
   import async_rx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] char_i,
   input  logic              noise_i,
   input  logic              frame_i,
   input  logic              rd_en_i,
   input  logic              rd_sel_i,
   output rx_flags_t         flags_o,
   output logic [DATA_W-1:0] data_o
);

   rx_flags_t         flags_q, arm_q, clr, eff, flags_n;
   logic [DATA_W-1:0] data_q;
   logic              stat_rd, data_rd, blocked;

   assign stat_rd = rd_en_i && !rd_sel_i;
   assign data_rd = rd_en_i &&  rd_sel_i;
   assign clr     = data_rd ? arm_q : rx_flags_t'('0);
   assign eff     = flags_q & ~clr;
   assign blocked = eff.full | eff.frame;

   always_comb begin
      flags_n = eff;
      if (done_i) begin
         if (blocked) begin
            flags_n.ovr = 1'b1;
         end else begin
            flags_n.full  = 1'b1;
            flags_n.noise = eff.noise | noise_i;
            flags_n.frame = frame_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         arm_q   <= '0;
         data_q  <= '0;
      end else begin
         flags_q <= flags_n;
         if (stat_rd)      arm_q <= flags_q;
         else if (data_rd) arm_q <= '0;
         if (done_i && !blocked) data_q <= char_i;
      end
   end

   assign flags_o = flags_q;
   assign data_o  = data_q;

   p_frame_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.frame |-> flags_q.full);

   p_noise_with_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q.noise) |-> flags_q.full);

   p_overrun_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && flags_q.full && !clr.full) |=> ($stable(data_q) && flags_q.ovr));

   p_frame_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && flags_q.frame && !clr.frame) |=> $stable(data_q));

   p_overrun_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && frame_i && flags_q.full && !clr.full) |=> !$rose(flags_q.frame));

   p_full_clears_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_q.full) |-> $past(rd_en_i && rd_sel_i));

endmodule

// File: rtl/async_rx_status.sv
module async_rx_status
   import async_rx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          VOTE3       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick_i,
   input  logic              rxd_i,
   input  logic              rd_en_i,
   input  logic              rd_sel_i,
   output logic [DATA_W-1:0] rd_data_o
);

   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 8");
      end
      if (DATA_W < FLAGS_W) begin : g_bad_width
         $error("DATA_W must hold the status word");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_sync;
   logic              char_done;
   logic [DATA_W-1:0] char_data;
   logic              char_noise;
   logic              char_frame;
   rx_flags_t         flags;
   logic [DATA_W-1:0] buf_data;

   async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (rx_sync)
   );

   async_rx_sampler #(.OVS(OVS), .DATA_W(DATA_W), .VOTE3(VOTE3)) u_sampler (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (os_tick_i),
      .rxs_i       (rx_sync),
      .done_o      (char_done),
      .data_o      (char_data),
      .noise_o     (char_noise),
      .frame_err_o (char_frame)
   );

   async_rx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_i   (char_done),
      .char_i   (char_data),
      .noise_i  (char_noise),
      .frame_i  (char_frame),
      .rd_en_i  (rd_en_i),
      .rd_sel_i (rd_sel_i),
      .flags_o  (flags),
      .data_o   (buf_data)
   );

   assign rd_data_o = rd_sel_i ? buf_data : DATA_W'(flags);

endmodule

// File: tb/async_rx_status_bench.sv
module async_rx_status_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       rxd = 1'b1;
   logic       rd_en = 1'b0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   async_rx_status u_async_rx_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .os_tick_i (os_tick),
      .rxd_i     (rxd),
      .rd_en_i   (rd_en),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data)
   );

   // Monitor: compares each read against the queued expectation.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rd_en) begin
            exp_t it;
            n_vec++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL unexpected read: actual %02h expected none", rd_data);
            end else begin
               it = exp_q.pop_front();
               if (rd_data !== it.val) begin
                  n_bad++;
                  $display("FAIL %s: actual %02h expected %02h", it.tag, rd_data, it.val);
               end
            end
         end
      end
   end

   task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
      exp_t it;
      it.val = exp;
      it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      rd_en  = 1'b1;
      rd_sel = sel;
      @(negedge clk);
      rd_en  = 1'b0;
   endtask

   // Driver: glitch selects a bit cell (0 start, 1..8 data, 9 stop) whose sample 8 is inverted.
   task automatic send(input logic [7:0] b, input logic stop, input int glitch);
      logic [9:0] fr;
      fr = {stop, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            rxd = (glitch == i && k == 8) ? ~fr[i] : fr[i];
         end
      end
      @(negedge clk);
      rxd = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      rd(1'b0, 8'h00, "R1 status after reset");
      rd(1'b1, 8'h00, "R1 buffer after reset");

      send(8'hA5, 1'b1, -1);
      rd(1'b0, 8'h01, "R2 full after frame");
      rd(1'b1, 8'hA5, "R2 received byte");
      rd(1'b0, 8'h00, "R3 full cleared by sequence");

      send(8'h3C, 1'b1, -1);
      rd(1'b1, 8'h3C, "R3 unarmed buffer read");
      rd(1'b0, 8'h01, "R3 full kept without status read");
      send(8'h81, 1'b1, -1);
      rd(1'b0, 8'h03, "R4 overrun flagged");
      rd(1'b1, 8'h3C, "R4 buffer kept old byte");
      rd(1'b0, 8'h00, "R9 overrun cleared");

      send(8'h5A, 1'b1, 4);
      rd(1'b0, 8'h05, "R5 noise in data bit");
      rd(1'b1, 8'h5A, "R5 voted data byte");
      send(8'hC3, 1'b1, 0);
      rd(1'b0, 8'h05, "R5 noise in start bit");
      rd(1'b1, 8'hC3, "R5 byte after start glitch");
      send(8'h0F, 1'b1, 9);
      rd(1'b0, 8'h05, "R5 noise in stop bit");
      rd(1'b1, 8'h0F, "R5 byte after stop glitch");
      rd(1'b0, 8'h00, "R9 noise cleared");

      send(8'h77, 1'b0, -1);
      rd(1'b0, 8'h09, "R6 framing with full");
      send(8'h12, 1'b1, -1);
      rd(1'b0, 8'h0B, "R7 blocked by framing");
      rd(1'b1, 8'h77, "R7 buffer unchanged");
      rd(1'b0, 8'h00, "R9 framing cleared");

      send(8'h11, 1'b1, -1);
      send(8'h22, 1'b0, -1);
      rd(1'b0, 8'h03, "R8 overrun outranks framing");
      rd(1'b1, 8'h11, "R8 buffer holds first byte");
      rd(1'b0, 8'h00, "R8 flags cleared");

      send(8'h44, 1'b1, 2);
      rd(1'b1, 8'h44, "R9 buffer read without arm");
      rd(1'b0, 8'h05, "R9 flags survive unarmed read");
      rd(1'b1, 8'h44, "R9 armed buffer read");
      rd(1'b0, 8'h00, "R9 flags cleared after arm");
      rd(1'b0, 8'h00, "R9 status read with flags clear");
      send(8'h66, 1'b1, 6);
      rd(1'b1, 8'h66, "R9 stale arm gives no clear");
      rd(1'b0, 8'h05, "R9 flags still set");
      rd(1'b1, 8'h66, "R9 final clear");

      @(negedge clk);
      rxd = 1'b0;
      repeat (5) @(negedge clk);
      rxd = 1'b1;
      repeat (60) @(negedge clk);
      rd(1'b0, 8'h00, "R10 false start ignored");
      send(8'h96, 1'b1, -1);
      rd(1'b0, 8'h01, "R10 receiver recovers");
      rd(1'b1, 8'h96, "R10 byte after false start");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule